// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence of one SDRAM burst. When a read or write column command is presented, the block captures the starting column and the mode settings. From the next clock on it presents one column address per cycle until the programmed number of beats has been issued. The beats walk through the burst-aligned group of columns that contains the start column. The walk either counts upward with wrap-around inside the group, or XORs the beat index into the low column bits.

A new column command is accepted on any clock, including in the middle of a running burst, and the new burst starts at once. A terminate strobe stops the current burst. A mode option turns every write into a single-beat access while reads keep the programmed length. The column width is a parameter, so the block serves organisations with 9, 10 or 11 column bits.

Top module: `sdram_burst_colgen`

## Requirements
- R1: `len_sel` picks the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. A burst that is not interrupted holds `valid` high for exactly that many consecutive cycles. The first beat appears on the clock after `start` is sampled.
- R2: With `ilv` = 0 (sequential), beat n of a burst of length L shows the start column with its low log2(L) bits replaced by (start_low + n) mod L.
- R3: With `ilv` = 1 (interleave), beat n shows the start column with its low log2(L) bits replaced by start_low XOR n.
- R4: The column bits above the low log2(L) bits equal those of the start column on every beat.
- R5: `last` is high only on the final beat (beat L-1). When the burst is not restarted, `valid` and `last` are low on the following cycle.
- R6: With `wr_one` = 1, a start that has `is_wr` = 1 produces a single beat with `last` high on that beat. Reads keep the length chosen by `len_sel`. With `wr_one` = 0, writes keep the programmed length.
- R7: `stop` sampled high without `start` clears `valid` and `last` on the next cycle, and no further addresses are produced.
- R8: `start` is accepted on any cycle. The next cycle shows beat 0 of the new burst, even in the middle of a burst, and `start` takes priority over a simultaneous `stop`.
- R9: After reset, `valid` and `last` are 0 and `col` is 0.
- R10: `len_sel`, `ilv`, `wr_one` and `is_wr` are sampled only together with `start`. Changing them during a burst has no effect on its addresses or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_sel | input | 2 | Burst length code (R1) |
| ilv | input | 1 | 1 = interleave ordering, 0 = sequential |
| wr_one | input | 1 | 1 = writes are single-beat |
| start | input | 1 | Column command strobe |
| is_wr | input | 1 | Command is a write |
| start_col | input | COL_W | Starting column |
| stop | input | 1 | Burst terminate strobe |
| col | output | COL_W | Current column address |
| valid | output | 1 | `col` carries a beat |
| last | output | 1 | Current beat is the final one |

## Verification
A wrong beat counter or a wrong latched length shows at the ports within one burst. `last` appears on the wrong beat, or `valid` stays high one cycle too long or drops one cycle too early. A corrupted captured base column or ordering bit shows on the very next beat as a wrong `col`. Upper column bits that change inside a burst are visible on the first beat that crosses the group boundary. A start or stop that is ignored shows on the cycle that follows it.

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       len_sel,
  input  logic             ilv,
  input  logic             wr_one,
  input  logic             start,
  input  logic             is_wr,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             last
);
  localparam int BW = 3;

  logic [COL_W-1:0] base_q;
  logic [BW-1:0]    beat_q;
  logic [BW-1:0]    lmask_q;
  logic             ilv_q;
  logic             valid_q;

  logic [BW-1:0]    len_m1_d;
  logic [BW-1:0]    low;
  logic [COL_W-1:0] mask;

  assign len_m1_d = (is_wr && wr_one) ? 3'd0
                  : {len_sel == 2'd3, len_sel[1], len_sel != 2'd0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      beat_q  <= '0;
      lmask_q <= '0;
      ilv_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (start) begin
      base_q  <= start_col;
      beat_q  <= '0;
      lmask_q <= len_m1_d;
      ilv_q   <= ilv;
      valid_q <= 1'b1;
    end else if (stop || last) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
    end else if (valid_q) begin
      beat_q  <= beat_q + 3'd1;
    end
  end

  assign low   = ilv_q ? (base_q[BW-1:0] ^ beat_q) : (base_q[BW-1:0] + beat_q);
  assign mask  = {{(COL_W-BW){1'b0}}, lmask_q};
  assign col   = (base_q & ~mask) | ({{(COL_W-BW){1'b0}}, low} & mask);
  assign valid = valid_q;
  assign last  = valid_q && (beat_q == lmask_q);

  a_r1_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (beat_q <= lmask_q));
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (valid && col == $past(start_col)));
  a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> (!valid && !last));
  a_r5_end: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !valid);
  a_r4_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !last && !start && !stop) |=> ((col & ~mask) == $past(col & ~mask)));
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !last);
endmodule

// File: tb/sdram_burst_colgen_tb_top.sv
`timescale 1ns/1ps
module sdram_burst_colgen_tb_top;
  localparam int CW = 9;
  logic clk = 0, rst_n = 0;
  logic [1:0] len_sel = 0;
  logic ilv = 0, wr_one = 0, start = 0, is_wr = 0, stop = 0;
  logic [CW-1:0] start_col = 0;
  logic [CW-1:0] col;
  logic valid, last;
  int checks = 0, errors = 0;

  sdram_burst_colgen #(.COL_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .len_sel(len_sel), .ilv(ilv), .wr_one(wr_one),
    .start(start), .is_wr(is_wr), .start_col(start_col), .stop(stop),
    .col(col), .valid(valid), .last(last));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic int exp_col(int c, int len, int il, int n);
    int m = len - 1;
    int lo = il ? ((c & m) ^ n) : (((c & m) + n) & m);
    return (c & ~m) | lo;
  endfunction

  task automatic issue(int ls, int il, int wr, int wo, int c);
    len_sel = ls[1:0]; ilv = il[0]; is_wr = wr[0]; wr_one = wo[0];
    start_col = c[CW-1:0]; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic burst(int ls, int il, int wr, int wo, int c, int scramble);
    int len = (wr != 0 && wo != 0) ? 1 : (1 << ls);
    issue(ls, il, wr, wo, c);
    if (scramble != 0) begin
      len_sel = ~ls[1:0]; ilv = ~il[0]; wr_one = 1; is_wr = 1;
    end
    for (int n = 0; n < len; n++) begin
      chk(il ? "R3 col" : "R2 col", int'(col), exp_col(c, len, il, n));
      chk("R4/R1 valid", int'(valid), 1);
      chk("R5 last", int'(last), (n == len - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk("R5/R1 valid drops", int'(valid), 0);
    chk("R5 last drops", int'(last), 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R9 valid", int'(valid), 0);
    chk("R9 last", int'(last), 0);
    chk("R9 col", int'(col), 0);
    rst_n = 1;
    @(negedge clk);
    // R1 R2 R3 R4 sweep
    for (int ls = 0; ls < 4; ls++)
      for (int il = 0; il < 2; il++)
        for (int lo = 0; lo < 8; lo++)
          burst(ls, il, 0, 0, (lo + 8 * (ls * 5 + il * 17 + 3)) % (1 << CW), 0);
    // R6 write single-beat
    burst(3, 0, 1, 1, 13, 0);
    burst(2, 1, 0, 1, 6, 0);
    burst(3, 1, 1, 0, 29, 0);
    // R10 mode change mid-burst
    burst(3, 0, 0, 0, 'h1F5, 1);
    burst(2, 1, 0, 0, 'h0A2, 1);
    // R7 stop
    issue(3, 0, 0, 0, 'h44);
    @(negedge clk);
    chk("R7 beat1", int'(col), 'h45);
    stop = 1;
    @(negedge clk);
    stop = 0;
    chk("R7 valid", int'(valid), 0);
    chk("R7 last", int'(last), 0);
    @(negedge clk);
    chk("R7 stays idle", int'(valid), 0);
    // R8 restart mid-burst, start beats stop
    issue(3, 0, 0, 0, 'h05);
    @(negedge clk);
    len_sel = 2; ilv = 1; start_col = 'h1A3; start = 1; stop = 1;
    @(negedge clk);
    start = 0; stop = 0;
    for (int n = 0; n < 4; n++) begin
      chk("R8 col", int'(col), exp_col('h1A3, 4, 1, n));
      chk("R8 valid", int'(valid), 1);
      chk("R8 last", int'(last), n == 3 ? 1 : 0);
      @(negedge clk);
    end
    chk("R8 end", int'(valid), 0);
    // R8 back-to-back starts every clock
    for (int k = 0; k < 6; k++) begin
      len_sel = 3; ilv = 0; is_wr = 0; start_col = CW'(k * 37 + 2); start = 1;
      @(negedge clk);
      chk("R8 every clock", int'(col), (k * 37 + 2) % (1 << CW));
      chk("R8 first not last", int'(last), 0);
    end
    start = 0;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule